// File: doc/BRIEF.md
# Pixel Depth Unpacker

This block sits between a show-ahead word FIFO and a panel timing pipeline. On every cycle in which the pixel-clock enable is high and the FIFO has a word at its head, it cuts one pixel out of that head word and registers it on its outputs one cycle later. Six depth codes are supported. The four packed low depths deliver colour-table indices. The 16-bit depth delivers either a 5-6-5 or a 5-5-5 colour pixel. The wide depth uses a whole word per pixel.

A pixel counter walks through the head word. When the last pixel of the word is taken, the block pops the FIFO in that same cycle, so the next word is at the head in time for the following pixel enable. Control inputs can reverse the byte order of every word before extraction. They can also make packed pixels come from the least-significant end of the word. Colour output is laid out either as a 24-bit bus or as an 18-bit bus.

Top module: `pxu_unpacker`

## Requirements
- R1: `depth_sel` codes map as 0→1 bpp, 1→2 bpp, 2→4 bpp, 3→8 bpp, 4→16 bpp and 5→one pixel per 32-bit word. `fifo_pop` is asserted only in a cycle with `pix_en` high and the FIFO not empty, and only when that cycle takes the last pixel of the head word (32/bpp pixels per word).
- R2: Depth codes 0 to 3 give an index zero-extended on `pal_idx` with `pal_vld` high and `rgb_vld` low. Codes 4 and 5 give `rgb_vld` high and `pal_vld` low.
- R3: By default, packed pixels (codes 0 to 4) are taken starting at bit 31 and moving downward. With `lsb_first` high they are taken starting at bit 0 and moving upward.
- R4: With `byte_rev` high, the four bytes of the word are reversed before any extraction, at every depth.
- R5: With code 4 and `rgb555_sel` low, red is bits 15:11, green is 10:5 and blue is 4:0. Each component is widened to 8 bits by repeating its top bits below its LSB.
- R6: With code 4 and `rgb555_sel` high, red is bits 14:10, green is 9:5 and blue is 4:0. Bit 15 has no effect.
- R7: With code 5, every pixel enable pops one word. Red is taken from bits 23:16, green from 15:8 and blue from 7:0. Bits 31:24 have no effect.
- R8: With `bus18_sel` low, `rgb_data` is {R8,G8,B8}. With `bus18_sel` high, `rgb_data` is {6'b0,R6,G6,B6}, where each 6-bit value is the top six bits of the widened 8-bit component.
- R9: A pixel appears on the outputs in the cycle after its `pix_en` cycle. A cycle without `pix_en` yields no valid strobe and keeps the position within the word.
- R10: A `pix_en` cycle with an empty FIFO yields no pixel and no pop, and keeps the position within the word.
- R11: Depth codes 6 and 7 yield no pixel and no pop.
- R12: During reset, `pal_vld`, `rgb_vld` and `fifo_pop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable, one pixel per high cycle |
| fifo_data | input | 32 | Head word of the show-ahead FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Retire the head word this cycle |
| depth_sel | input | 3 | Depth code |
| rgb555_sel | input | 1 | 5-5-5 layout for the 16-bit depth |
| byte_rev | input | 1 | Reverse the byte order of each word |
| lsb_first | input | 1 | Take packed pixels from bit 0 upward |
| bus18_sel | input | 1 | 18-bit colour bus layout |
| pal_idx | output | 8 | Colour-table index |
| pal_vld | output | 1 | `pal_idx` holds a new pixel |
| rgb_data | output | 24 | Colour pixel |
| rgb_vld | output | 1 | `rgb_data` holds a new pixel |

## Verification
Two events can land in the same cycle: the last pixel of a word is taken, and the FIFO pops so that the next word arrives at the head. The bench provokes this by queueing two 4-bpp words back to back and issuing nine pixel enables in a row. It counts pops after the seventh and after the eighth enable, and it requires the ninth pixel to be the first nibble of the second word, with no gap or repeat. The wide depth makes both events coincide on every enable, and two queued wide words must come out on consecutive pixels.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  localparam int unsigned COMP_W = 8;          // widened colour component
  localparam int unsigned BUS18_COMP_W = 6;    // component on the narrow bus

  localparam logic [2:0] DEP_1BPP  = 3'd0;
  localparam logic [2:0] DEP_2BPP  = 3'd1;
  localparam logic [2:0] DEP_4BPP  = 3'd2;
  localparam logic [2:0] DEP_8BPP  = 3'd3;
  localparam logic [2:0] DEP_16BPP = 3'd4;
  localparam logic [2:0] DEP_WIDE  = 3'd5;

  // log2 of bits per pixel; wide and reserved codes span a whole word
  function automatic logic [2:0] depth_lg(input logic [2:0] d);
    case (d)
      DEP_1BPP:  depth_lg = 3'd0;
      DEP_2BPP:  depth_lg = 3'd1;
      DEP_4BPP:  depth_lg = 3'd2;
      DEP_8BPP:  depth_lg = 3'd3;
      DEP_16BPP: depth_lg = 3'd4;
      default:   depth_lg = 3'd5;
    endcase
  endfunction

  function automatic logic depth_valid(input logic [2:0] d);
    depth_valid = (d <= DEP_WIDE);
  endfunction

  function automatic logic depth_indexed(input logic [2:0] d);
    depth_indexed = (d <= DEP_8BPP);
  endfunction

  function automatic logic [COMP_W-1:0] widen5(input logic [4:0] c);
    widen5 = {c, c[4:2]};
  endfunction

  function automatic logic [COMP_W-1:0] widen6(input logic [5:0] c);
    widen6 = {c, c[5:4]};
  endfunction

endpackage

// File: rtl/pxu_rst_sync.sv
module pxu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run = sync_q[STAGES-1];

endmodule

// File: rtl/pxu_slot_ctrl.sv
module pxu_slot_ctrl
  import pxu_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned SLOT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              pix_en,
  input  logic              fifo_empty,
  input  logic [2:0]        depth_sel,
  output logic [SLOT_W-1:0] slot,
  output logic              emit,
  output logic              pop
);

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_d;
  logic [SLOT_W-1:0] last_slot;
  logic              at_last;
  logic [2:0]        lg;

  always_comb begin
    lg        = depth_lg(depth_sel);
    last_slot = SLOT_W'((WORD_W >> lg) - 1);
    at_last   = (slot_q >= last_slot);
    emit      = run && pix_en && !fifo_empty && depth_valid(depth_sel);
    pop       = emit && at_last;
    slot_d    = slot_q;
    if (emit) begin
      slot_d = at_last ? '0 : slot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot = slot_q;

endmodule

// File: rtl/pxu_extract.sv
module pxu_extract
  import pxu_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned SLOT_W = $clog2(WORD_W),
  localparam int unsigned SH_W   = SLOT_W + 1,
  localparam int unsigned NBYTES = WORD_W / 8
) (
  input  logic [WORD_W-1:0] word,
  input  logic              byte_rev,
  input  logic              lsb_first,
  input  logic [2:0]        depth_sel,
  input  logic [SLOT_W-1:0] slot,
  output logic [15:0]       pix,
  output logic [23:0]       wide
);

  logic [WORD_W-1:0] swapped;
  logic [WORD_W-1:0] w;
  logic [2:0]        lg;
  logic [SH_W-1:0]   bpp;
  logic [SH_W-1:0]   ofs;
  logic [SH_W-1:0]   sh;
  logic [15:0]       mask;

  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
      assign swapped[8*b +: 8] = word[8*(NBYTES-1-b) +: 8];
    end
  endgenerate

  always_comb begin
    w    = byte_rev ? swapped : word;
    lg   = depth_lg(depth_sel);
    bpp  = SH_W'(1) << lg;
    ofs  = SH_W'(slot) << lg;
    sh   = lsb_first ? ofs : (SH_W'(WORD_W) - ofs - bpp);
    mask = (bpp >= SH_W'(16)) ? 16'hFFFF : 16'((32'd1 << bpp) - 32'd1);
    pix  = 16'(w >> sh) & mask;
    wide = w[23:0];
  end

endmodule

// File: rtl/pxu_color.sv
module pxu_color
  import pxu_pkg::*;
#(
  parameter int unsigned BUS_W = 3 * COMP_W
) (
  input  logic             wide_sel,
  input  logic             rgb555_sel,
  input  logic             bus18_sel,
  input  logic [15:0]      half,
  input  logic [23:0]      wide,
  output logic [BUS_W-1:0] rgb
);

  logic [COMP_W-1:0] r8, g8, b8;
  logic [4:0]        r5, b5, g5;
  logic [5:0]        g6;

  always_comb begin
    r5 = rgb555_sel ? half[14:10] : half[15:11];
    g5 = half[9:5];
    g6 = half[10:5];
    b5 = half[4:0];
    if (wide_sel) begin
      r8 = wide[23:16];
      g8 = wide[15:8];
      b8 = wide[7:0];
    end else begin
      r8 = widen5(r5);
      g8 = rgb555_sel ? widen5(g5) : widen6(g6);
      b8 = widen5(b5);
    end
    if (bus18_sel) begin
      rgb = BUS_W'({r8[COMP_W-1 -: BUS18_COMP_W],
                    g8[COMP_W-1 -: BUS18_COMP_W],
                    b8[COMP_W-1 -: BUS18_COMP_W]});
    end else begin
      rgb = BUS_W'({r8, g8, b8});
    end
  end

endmodule

// File: rtl/pxu_unpacker.sv
module pxu_unpacker
  import pxu_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 8,
  localparam int unsigned BUS_W  = 3 * COMP_W,
  localparam int unsigned SLOT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  input  logic [2:0]        depth_sel,
  input  logic              rgb555_sel,
  input  logic              byte_rev,
  input  logic              lsb_first,
  input  logic              bus18_sel,
  output logic [IDX_W-1:0]  pal_idx,
  output logic              pal_vld,
  output logic [BUS_W-1:0]  rgb_data,
  output logic              rgb_vld
);

  logic              run;
  logic [SLOT_W-1:0] slot;
  logic              emit;
  logic [15:0]       pix;
  logic [23:0]       wide;
  logic [BUS_W-1:0]  rgb_c;

  logic              pal_vld_d, rgb_vld_d;
  logic [IDX_W-1:0]  pal_idx_d;
  logic [BUS_W-1:0]  rgb_data_d;
  logic              pal_vld_q, rgb_vld_q;
  logic [IDX_W-1:0]  pal_idx_q;
  logic [BUS_W-1:0]  rgb_data_q;

  pxu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  pxu_slot_ctrl #(.WORD_W(WORD_W)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .pix_en     (pix_en),
    .fifo_empty (fifo_empty),
    .depth_sel  (depth_sel),
    .slot       (slot),
    .emit       (emit),
    .pop        (fifo_pop)
  );

  pxu_extract #(.WORD_W(WORD_W)) u_extract (
    .word      (fifo_data),
    .byte_rev  (byte_rev),
    .lsb_first (lsb_first),
    .depth_sel (depth_sel),
    .slot      (slot),
    .pix       (pix),
    .wide      (wide)
  );

  pxu_color #(.BUS_W(BUS_W)) u_color (
    .wide_sel   (depth_sel == DEP_WIDE),
    .rgb555_sel (rgb555_sel),
    .bus18_sel  (bus18_sel),
    .half       (pix),
    .wide       (wide),
    .rgb        (rgb_c)
  );

  // next-state
  always_comb begin
    pal_vld_d  = emit && depth_indexed(depth_sel);
    rgb_vld_d  = emit && !depth_indexed(depth_sel);
    pal_idx_d  = pal_vld_d ? IDX_W'(pix[7:0]) : pal_idx_q;
    rgb_data_d = rgb_vld_d ? rgb_c : rgb_data_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pal_vld_q  <= 1'b0;
      rgb_vld_q  <= 1'b0;
      pal_idx_q  <= '0;
      rgb_data_q <= '0;
    end else begin
      pal_vld_q  <= pal_vld_d;
      rgb_vld_q  <= rgb_vld_d;
      pal_idx_q  <= pal_idx_d;
      rgb_data_q <= rgb_data_d;
    end
  end

  assign pal_vld  = pal_vld_q;
  assign rgb_vld  = rgb_vld_q;
  assign pal_idx  = pal_idx_q;
  assign rgb_data = rgb_data_q;

endmodule

// File: rtl/pxu_unpacker_chk.sv
module pxu_unpacker_chk #(
  parameter int unsigned BUS_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             fifo_empty,
  input logic             fifo_pop,
  input logic [2:0]       depth_sel,
  input logic             bus18_sel,
  input logic             pal_vld,
  input logic [BUS_W-1:0] rgb_data,
  input logic             rgb_vld
);

  logic [1:0] live_cnt;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              live_cnt <= 2'd0;
    else if (live_cnt != 2'd2) live_cnt <= live_cnt + 2'd1;
  end
  assign live = (live_cnt == 2'd2);

  AST_POP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> pix_en);                                                  // R1
  AST_VLD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pal_vld && rgb_vld));                                                // R2
  AST_WIDE_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (live && pix_en && !fifo_empty && depth_sel == 3'd5) |-> fifo_pop);    // R7
  AST_BUS18_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_vld && $past(bus18_sel)) |-> (rgb_data[BUS_W-1:18] == '0));       // R8
  AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> (!pal_vld && !rgb_vld));                                   // R9
  AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !fifo_pop);                                             // R10
  AST_EMPTY_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && fifo_empty) |=> (!pal_vld && !rgb_vld));                    // R10
  AST_RSVD_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_sel[2:1] == 2'b11) |-> !fifo_pop);                              // R11

endmodule

bind pxu_unpacker pxu_unpacker_chk #(.BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_en     (pix_en),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .depth_sel  (depth_sel),
  .bus18_sel  (bus18_sel),
  .pal_vld    (pal_vld),
  .rgb_data   (rgb_data),
  .rgb_vld    (rgb_vld)
);

// File: tb/pxu_unpacker_tb.sv
`timescale 1ns/1ps
module pxu_unpacker_tb;

  localparam int WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic [31:0] fifo_data;
  logic        fifo_empty;
  logic        fifo_pop;
  logic [2:0]  depth_sel = 3'd0;
  logic        rgb555_sel = 1'b0, byte_rev = 1'b0, lsb_first = 1'b0, bus18_sel = 1'b0;
  logic [7:0]  pal_idx;
  logic        pal_vld;
  logic [23:0] rgb_data;
  logic        rgb_vld;

  int total = 0, bad = 0, cyc = 0, pops = 0;
  int wr_p = 0, rd_p = 0;
  logic [31:0] fq [0:15];

  always #2.5 clk = ~clk;

  pxu_unpacker u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .fifo_data(fifo_data),
    .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .depth_sel(depth_sel),
    .rgb555_sel(rgb555_sel), .byte_rev(byte_rev), .lsb_first(lsb_first),
    .bus18_sel(bus18_sel), .pal_idx(pal_idx), .pal_vld(pal_vld),
    .rgb_data(rgb_data), .rgb_vld(rgb_vld)
  );

  assign fifo_data  = fq[rd_p[3:0]];
  assign fifo_empty = (wr_p == rd_p);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fifo_pop) begin
      rd_p <= rd_p + 1;
      pops <= pops + 1;
    end
    if (cyc == WD_LIMIT) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // {depth[2:0], c555, rev, lsb, b18, word[31:0], is_pal, exp[23:0]}
  localparam logic [63:0] VEC [0:15] = '{
    {3'd0, 4'b0000, 32'h8000_0000, 1'b1, 24'h000001},
    {3'd0, 4'b0010, 32'h0000_0001, 1'b1, 24'h000001},
    {3'd1, 4'b0000, 32'hC000_0000, 1'b1, 24'h000003},
    {3'd2, 4'b0100, 32'h1234_56A7, 1'b1, 24'h00000A},
    {3'd2, 4'b0010, 32'h1234_5678, 1'b1, 24'h000008},
    {3'd3, 4'b0000, 32'hDE00_0000, 1'b1, 24'h0000DE},
    {3'd3, 4'b0110, 32'h1122_3344, 1'b1, 24'h000011},
    {3'd4, 4'b0000, 32'hF800_0000, 1'b0, 24'hFF0000},
    {3'd4, 4'b0000, 32'h8410_0000, 1'b0, 24'h848284},
    {3'd4, 4'b1000, 32'h8000_0000, 1'b0, 24'h000000},
    {3'd4, 4'b1000, 32'h4210_0000, 1'b0, 24'h848484},
    {3'd4, 4'b0010, 32'h0000_001F, 1'b0, 24'h0000FF},
    {3'd4, 4'b0001, 32'h8410_0000, 1'b0, 24'h021821},
    {3'd5, 4'b0001, 32'h00FC_8004, 1'b0, 24'h03F801},
    {3'd5, 4'b0100, 32'hC3B2_A100, 1'b0, 24'hA1B2C3},
    {3'd5, 4'b0000, 32'hFF12_3456, 1'b0, 24'h123456}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    fq[wr_p[3:0]] = w;
    wr_p = wr_p + 1;
  endtask

  task automatic pix();
    @(negedge clk) pix_en = 1'b1;
    @(negedge clk) pix_en = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] d, input logic c555, input logic rev,
                     input logic lsb, input logic b18);
    depth_sel = d; rgb555_sel = c555; byte_rev = rev; lsb_first = lsb; bus18_sel = b18;
  endtask

  initial begin
    int p0;
    for (int i = 0; i < 16; i++) fq[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk("R12 pal_vld in reset", {31'b0, pal_vld}, 32'd0);
    chk("R12 rgb_vld in reset", {31'b0, rgb_vld}, 32'd0);
    chk("R12 fifo_pop in reset", {31'b0, fifo_pop}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: first pixel of each word, then drain the word
    for (int i = 0; i < 16; i++) begin
      logic [63:0] v;
      int n;
      v = VEC[i];
      cfg(v[63:61], v[60], v[59], v[58], v[57]);
      push(v[56:25]);
      pix();
      if (v[24]) begin
        chk("R2/R3/R4 pal_vld", {31'b0, pal_vld}, 32'd1);
        chk("R2 rgb_vld low on index", {31'b0, rgb_vld}, 32'd0);
        chk("R3/R4 pal_idx", {24'b0, pal_idx}, {24'b0, v[7:0]});
      end else begin
        chk("R2 rgb_vld", {31'b0, rgb_vld}, 32'd1);
        chk("R2 pal_vld low on colour", {31'b0, pal_vld}, 32'd0);
        chk("R5/R6/R7/R8 rgb_data", {8'b0, rgb_data}, {8'b0, v[23:0]});
      end
      n = (v[63:61] == 3'd5) ? 1 : (32 >> v[63:61]);
      for (int k = 1; k < n; k++) pix();
      chk("R1 word retired after 32/bpp pixels", wr_p - rd_p, 0);
    end

    // R1/R3: two 4-bpp words back to back, pop lands with the 8th pixel
    cfg(3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    push(32'h1234_5678);
    push(32'h9ABC_DEF0);
    p0 = pops;
    for (int k = 0; k < 8; k++) begin
      pix();
      chk("R3 msb-first nibble order", {24'b0, pal_idx}, k + 1);
      if (k == 6) chk("R1 no pop before last pixel", pops - p0, 0);
    end
    chk("R1 one pop after last pixel", pops - p0, 1);
    pix();
    chk("R1 next word follows without gap", {24'b0, pal_idx}, 32'h9);
    for (int k = 1; k < 8; k++) pix();

    // R9: idle cycles keep position
    cfg(3'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    push(32'hA1B2_C3D4);
    pix();
    chk("R9 first byte", {24'b0, pal_idx}, 32'hA1);
    repeat (3) @(negedge clk);
    chk("R9 no strobe while idle", {30'b0, pal_vld, rgb_vld}, 32'd0);
    pix();
    chk("R9 position held over idle", {24'b0, pal_idx}, 32'hB2);
    pix(); pix();

    // R10: empty FIFO
    cfg(3'd3, 1'b0, 1'b0, 1'b1, 1'b0);
    p0 = pops;
    pix();
    chk("R10 no strobe on empty", {30'b0, pal_vld, rgb_vld}, 32'd0);
    chk("R10 no pop on empty", pops - p0, 0);
    push(32'h0000_0077);
    pix();
    chk("R10 position held after empty", {24'b0, pal_idx}, 32'h77);
    pix(); pix(); pix();

    // R11: reserved depth codes
    push(32'h5555_AAAA);
    p0 = pops;
    cfg(3'd6, 1'b0, 1'b0, 1'b0, 1'b0);
    pix();
    chk("R11 code 6 no strobe", {30'b0, pal_vld, rgb_vld}, 32'd0);
    cfg(3'd7, 1'b0, 1'b0, 1'b0, 1'b0);
    pix();
    chk("R11 code 7 no strobe", {30'b0, pal_vld, rgb_vld}, 32'd0);
    chk("R11 no pop on reserved", pops - p0, 0);
    cfg(3'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    pix();
    chk("R11 position held over reserved", {24'b0, pal_idx}, 32'h55);
    pix(); pix(); pix();

    // R7: wide words back to back
    cfg(3'd5, 1'b0, 1'b0, 1'b0, 1'b0);
    push(32'h0011_2233);
    push(32'h0044_5566);
    pix();
    chk("R7 first wide pixel", {8'b0, rgb_data}, 32'h0011_2233);
    pix();
    chk("R7 second wide pixel", {8'b0, rgb_data}, 32'h0044_5566);
    chk("R7 both words popped", wr_p - rd_p, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule